// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block is the column-burst engine of a synchronous DRAM device model. Decoded READ and WRITE commands arrive with a bank and a starting column. Settings taken from a mode-register input (burst length, burst order, read latency and a write-single flag) decide how the block walks the columns of the burst. For every beat it produces a column address. It raises a strobe that tells the array to take a write word at the coming edge. For reads it delivers a delayed read-valid strobe and the matching column, so the array knows which word to drive.

A registered copy of CKE forms the internal clock enable. When CKE is sampled LOW at one edge, the next edge is suspended. At a suspended edge the burst counter, the column output, the read-latency pipe and command acceptance all hold. In write-single mode every WRITE covers exactly one column. READs keep the programmed length and order in that mode.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the block has no burst in progress: `col_valid`, `wr_capture` and `rd_valid` are 0, and the internal clock enable is active.
- R2: `mode_bl` sets the burst length at command time: code 0 gives 1 column, 1 gives 2, 2 gives 4 and 3 gives 8. `col_valid` stays high for that many active edges, counting the command edge.
- R3: With `mode_ilv`=0 (sequential order), beat k gives low column bits (start+k) mod BL. The column bits above the BL-aligned block keep the start value.
- R4: With `mode_ilv`=1 (interleaved order), beat k gives low column bits start XOR k. The upper bits are unchanged.
- R5: With `mode_wsingle`=1 at command time, a WRITE gives exactly one column, whatever `mode_bl` says.
- R6: With `mode_wsingle`=1, a READ still uses the programmed length and order.
- R7: If CKE is sampled LOW at a clock edge, the next edge is suspended. At that edge the counter, column outputs and read pipe do not advance, and the burst continues in order afterwards.
- R8: `wr_capture` is high during a write beat only when the coming edge is active. A suspended write beat produces no capture, and that same column is captured at the next active edge.
- R9: `rd_valid` and `rd_col` show read beat k exactly `mode_cl` active edges after the command edge (`mode_cl` is 1, 2 or 3). Over a suspended edge they hold their value.
- R10: A READ or WRITE accepted during a burst ends that burst and starts the new one at beat 0.
- R11: A command presented when the coming edge is suspended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable, sampled every edge |
| cmd_valid | input | 1 | READ or WRITE command present |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Starting column |
| mode_bl | input | 2 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order |
| mode_cl | input | 2 | Read latency in active edges (1..3) |
| mode_wsingle | input | 1 | 1 = WRITEs are single column |
| col_valid | output | 1 | A burst beat is current |
| col_write | output | 1 | Current beat belongs to a WRITE |
| col_bank | output | BANK_W | Bank of the current burst |
| col_addr | output | COL_W | Column of the current beat |
| wr_capture | output | 1 | Take the write word at the coming edge |
| rd_valid | output | 1 | Read word on the output |
| rd_col | output | COL_W | Column of the read word on the output |

## Verification
The assertions assume that `mode_cl` holds a value from 1 to 3. They also assume it changes only while no read word is in the latency pipe, because the output tap moves at once. The counter bound assumes that the burst length code is sampled only at command edges. The stimulus changes `mode_cl` only after a run of idle active cycles long enough to drain the pipe. It draws burst length, order and write-single freely for each command, because those settings are latched with the command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int unsigned LEN_LOG = 3;

  typedef logic [LEN_LOG-1:0] beat_t;
  typedef logic [LEN_LOG:0]   len_t;

  typedef enum logic [1:0] {
    BLC_1 = 2'd0,
    BLC_2 = 2'd1,
    BLC_4 = 2'd2,
    BLC_8 = 2'd3
  } bl_code_e;

  function automatic len_t len_of(bl_code_e code, logic single_wr, logic is_wr);
    len_t n;
    if (single_wr && is_wr) n = len_t'(1);
    else                    n = len_t'(1) << code;
    return n;
  endfunction

  function automatic beat_t low_offset(beat_t start_low, beat_t cnt, len_t len, logic ilv);
    beat_t mask;
    beat_t r;
    mask = beat_t'(len - len_t'(1));
    if (ilv) r = (start_low ^ cnt) & mask;
    else     r = beat_t'(start_low + cnt) & mask;
    return r;
  endfunction

endpackage

// File: rtl/sdram_cke_gate.sv
module sdram_cke_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic act
);
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign act = cke_q;
endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [1:0]        mode_bl,
  input  logic              mode_ilv,
  input  logic              mode_wsingle,
  output logic              busy,
  output logic              is_wr,
  output logic              ilv,
  output logic              single,
  output len_t              len,
  output beat_t             cnt,
  output logic              last,
  output logic [COL_W-1:0]  start_col,
  output logic [BANK_W-1:0] bank
);
  len_t  len_new;

  assign len_new = len_of(bl_code_e'(mode_bl), mode_wsingle, cmd_write);
  assign last    = ({1'b0, cnt} + len_t'(1)) == len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      is_wr     <= 1'b0;
      ilv       <= 1'b0;
      single    <= 1'b0;
      len       <= len_t'(1);
      cnt       <= '0;
      start_col <= '0;
      bank      <= '0;
    end else if (act) begin
      if (cmd_valid) begin
        busy      <= 1'b1;
        is_wr     <= cmd_write;
        ilv       <= mode_ilv;
        single    <= mode_wsingle && cmd_write;
        len       <= len_new;
        cnt       <= '0;
        start_col <= cmd_col;
        bank      <= cmd_bank;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + beat_t'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] start_col,
  input  beat_t            cnt,
  input  len_t             len,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] blk_mask;
  beat_t            off;

  always_comb begin
    blk_mask = COL_W'(len - len_t'(1));
    off      = low_offset(start_col[LEN_LOG-1:0], cnt, len, ilv);
    col      = (start_col & ~blk_mask) | COL_W'(off);
  end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  input  logic [1:0]       cl,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col
);
  logic [MAX_CL-1:0] v_q;
  logic [COL_W-1:0]  c_q [MAX_CL];

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          c_q[0] <= '0;
        end else if (act) begin
          v_q[0] <= in_valid;
          c_q[0] <= in_col;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[g] <= 1'b0;
          c_q[g] <= '0;
        end else if (act) begin
          v_q[g] <= v_q[g-1];
          c_q[g] <= c_q[g-1];
        end
      end
    end
  end

  int unsigned tap;
  always_comb begin
    if (cl == 2'd0)                      tap = 0;
    else if (int'(cl) > int'(MAX_CL))    tap = MAX_CL - 1;
    else                                 tap = int'(cl) - 1;
    rd_valid = v_q[tap];
    rd_col   = c_q[tap];
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [1:0]        mode_bl,
  input  logic              mode_ilv,
  input  logic [1:0]        mode_cl,
  input  logic              mode_wsingle,
  output logic              col_valid,
  output logic              col_write,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              wr_capture,
  output logic              rd_valid,
  output logic [COL_W-1:0]  rd_col
);
  logic             act;
  logic             busy, is_wr, b_ilv, b_single, b_last;
  len_t             b_len;
  beat_t            b_cnt;
  logic [COL_W-1:0] b_start;
  logic [COL_W-1:0] cur_col;
  logic             rd_beat;

  sdram_cke_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .act   (act)
  );

  sdram_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .act          (act),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_bank     (cmd_bank),
    .cmd_col      (cmd_col),
    .mode_bl      (mode_bl),
    .mode_ilv     (mode_ilv),
    .mode_wsingle (mode_wsingle),
    .busy         (busy),
    .is_wr        (is_wr),
    .ilv          (b_ilv),
    .single       (b_single),
    .len          (b_len),
    .cnt          (b_cnt),
    .last         (b_last),
    .start_col    (b_start),
    .bank         (col_bank)
  );

  sdram_col_gen #(.COL_W(COL_W)) u_col (
    .start_col (b_start),
    .cnt       (b_cnt),
    .len       (b_len),
    .ilv       (b_ilv),
    .col       (cur_col)
  );

  assign rd_beat = busy && !is_wr;

  sdram_read_pipe #(.COL_W(COL_W), .MAX_CL(MAX_CL)) u_rpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .in_valid (rd_beat),
    .in_col   (cur_col),
    .cl       (mode_cl),
    .rd_valid (rd_valid),
    .rd_col   (rd_col)
  );

  assign col_valid  = busy;
  assign col_write  = is_wr;
  assign col_addr   = cur_col;
  assign wr_capture = busy && is_wr && act;
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             act,
  input logic             cmd_valid,
  input logic             col_valid,
  input logic             col_write,
  input logic [COL_W-1:0] col_addr,
  input logic             rd_valid,
  input logic [COL_W-1:0] rd_col,
  input logic             b_single,
  input len_t             b_len,
  input beat_t            b_cnt
);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> ({1'b0, b_cnt} < b_len));

  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && col_valid && col_write && b_single && !cmd_valid) |=> !col_valid);

  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(col_addr) && $stable(col_valid) && $stable(b_cnt)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(rd_valid) && $stable(rd_col)));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cmd_valid) |=> (col_valid && b_cnt == '0));

  p_cmd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && cmd_valid && !col_valid) |=> !col_valid);
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .act       (act),
  .cmd_valid (cmd_valid),
  .col_valid (col_valid),
  .col_write (col_write),
  .col_addr  (col_addr),
  .rd_valid  (rd_valid),
  .rd_col    (rd_col),
  .b_single  (b_single),
  .b_len     (b_len),
  .b_cnt     (b_cnt)
);

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;
  localparam int COL_W = 10;
  localparam int BANK_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [1:0] mode_bl = 2'd0, mode_cl = 2'd2;
  logic mode_ilv = 1'b0, mode_wsingle = 1'b0;
  logic col_valid, col_write, wr_capture, rd_valid;
  logic [BANK_W-1:0] col_bank;
  logic [COL_W-1:0] col_addr, rd_col;

  always #4 clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .mode_bl(mode_bl), .mode_ilv(mode_ilv),
    .mode_cl(mode_cl), .mode_wsingle(mode_wsingle), .col_valid(col_valid),
    .col_write(col_write), .col_bank(col_bank), .col_addr(col_addr),
    .wr_capture(wr_capture), .rd_valid(rd_valid), .rd_col(rd_col));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string tag = "";

  // reference model state
  bit m_act = 1, m_busy = 0, m_wr = 0, m_ilv = 0;
  int m_cnt = 0, m_len = 1, m_start = 0, m_bank = 0;
  bit p_v[3];
  int p_c[3];

  function automatic int ref_col(int start, int k, int len, bit il);
    int lo, base;
    lo = start % len;
    base = start - lo;
    if (il) return base + (lo ^ k);
    return base + ((lo + k) % len);
  endfunction

  task automatic chk(string rq, int act_v, int exp_v, string what);
    n_tests++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act_v, exp_v, $time);
    end
  endtask

  function automatic string pick(string dflt);
    return (tag != "") ? tag : dflt;
  endfunction

  task automatic compare();
    int ecl;
    ecl = int'(mode_cl) - 1;
    chk(pick("R2"), int'(col_valid), int'(m_busy), "col_valid");
    if (m_busy) begin
      chk(pick(m_ilv ? "R4" : "R3"), int'(col_addr), ref_col(m_start, m_cnt, m_len, m_ilv), "col_addr");
      chk(pick("R2"), int'(col_write), int'(m_wr), "col_write");
      chk(pick("R2"), int'(col_bank), m_bank, "col_bank");
    end
    chk(pick("R8"), int'(wr_capture), int'(m_busy && m_wr && m_act), "wr_capture");
    chk(pick("R9"), int'(rd_valid), int'(p_v[ecl]), "rd_valid");
    if (p_v[ecl]) chk(pick("R9"), int'(rd_col), p_c[ecl], "rd_col");
  endtask

  task automatic step(bit v, bit w, int bank, int col, int bl, bit il, bit sg, bit ck);
    @(negedge clk);
    compare();
    cmd_valid = v; cmd_write = w; cmd_bank = BANK_W'(bank); cmd_col = COL_W'(col);
    mode_bl = 2'(bl); mode_ilv = il; mode_wsingle = sg; cke = ck;
    if (m_act) begin
      p_v[2] = p_v[1]; p_c[2] = p_c[1];
      p_v[1] = p_v[0]; p_c[1] = p_c[0];
      p_v[0] = m_busy && !m_wr;
      p_c[0] = m_busy ? ref_col(m_start, m_cnt, m_len, m_ilv) : 0;
      if (v) begin
        m_busy = 1; m_cnt = 0; m_len = (w && sg) ? 1 : (1 << bl);
        m_start = col; m_wr = w; m_ilv = il; m_bank = bank;
      end else if (m_busy) begin
        if (m_cnt == m_len - 1) m_busy = 0;
        else m_cnt++;
      end
    end
    m_act = ck;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(col_valid), 0, "col_valid in reset");
    chk("R1", int'(wr_capture), 0, "wr_capture in reset");
    chk("R1", int'(rd_valid), 0, "rd_valid in reset");
    rst_n = 1'b1;
    idle(2);

    // suspend at every position, both write modes, writes and reads, all latencies
    for (int cl = 1; cl <= 3; cl++) begin
      tag = "";
      idle(5);
      mode_cl = 2'(cl);
      for (int sg = 0; sg < 2; sg++)
        for (int w = 0; w < 2; w++)
          for (int pos = 0; pos < 9; pos++) begin
            tag = (w == 1 && sg == 1) ? "R5" : ((sg == 1) ? "R6" : "R7");
            step(1, bit'(w), pos % 4, 37 + pos * 13, 3, bit'(pos % 2), bit'(sg), pos == 0 ? 1'b0 : 1'b1);
            for (int k = 1; k < 12; k++) step(0, 0, 0, 0, 0, 0, 0, (k == pos) ? 1'b0 : 1'b1);
          end
    end
    tag = "";
    idle(5);

    // R10: truncation by a new command mid-burst
    tag = "R10";
    step(1, 0, 1, 100, 3, 0, 0, 1);
    idle(3);
    step(1, 1, 2, 205, 2, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 3, 6, 1, 0, 1, 1);
    idle(8);

    // R11: command presented while the coming edge is suspended
    tag = "R11";
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 50, 3, 0, 0, 1);
    idle(4);
    tag = "";
    idle(6);

    // constrained random
    for (int blk = 0; blk < 40; blk++) begin
      mode_cl = 2'(1 + ($urandom % 3));
      for (int i = 0; i < 80; i++) begin
        bit v;
        v = ($urandom % 6) == 0;
        step(v, bit'($urandom % 2), int'($urandom % 4), int'($urandom % 1024), int'($urandom % 4),
             bit'($urandom % 2), bit'($urandom % 2), ($urandom % 4) != 0);
      end
      idle(14);
    end

    @(negedge clk);
    compare();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule